// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor presents its best candidate for this processor: a valid flag, a 10-bit source number, an 8-bit priority value and, for software-generated sources, the number of the processor that raised it. The block forwards the candidate on a level request line when three things hold. The interface is switched on. The candidate's priority value is strictly below a programmable threshold. No interrupt is already being serviced.

Software reaches the block through a simple 32-bit register port with four word slots: control (slot 0), priority threshold (slot 1), acknowledge (slot 2, read only) and completion (slot 3, write only). A read of the acknowledge slot hands over the forwarded source and makes it the single serviced interrupt. At the same moment the distributor gets a one-cycle notice, so it can mark the source active and drop any edge-latched pending state. Software later writes the source number to the completion slot. The block then frees its service slot and sends the distributor a one-cycle completion notice. Nested servicing is not supported: while one interrupt is in service, nothing else is forwarded.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the control and threshold slots read 0, the request line is low, no interrupt is in service and neither notice pulses.
- R2: Bit 0 of the control slot (read back in bit 0, other bits read 0) switches forwarding on; while it is 0 the request line stays low. The threshold slot reads back its 8-bit value in bits 7:0.
- R3: The request line is high exactly when forwarding is on, a candidate is valid with source number below 1020, its priority value is strictly less than the threshold, and no interrupt is in service.
- R4: A read of the acknowledge slot while the request line is high returns the source number in bits 9:0. For sources 0 to 15 it also returns the requesting processor number in bits 12:10; for other sources bits 12:10 are 0. Bits 31:13 are always 0.
- R5: Such a read raises the acknowledge notice for one cycle, carrying the source number, in the cycle the read data appears. The source becomes the one in service and the request line falls.
- R6: A read of the acknowledge slot while the request line is low returns 1023 and has no effect: no notice, and no change of service state.
- R7: Candidates with source numbers 1020 to 1023 never raise the request line.
- R8: A completion write whose bits 9:0 equal the source in service frees the service slot and raises the completion notice for one cycle, carrying that source number, in the cycle after the write.
- R9: A completion write with any other number, or with nothing in service, is ignored: no notice, and the service slot keeps its source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word slot |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, registered, valid the cycle after the read strobe |
| cand_vld_i | input | 1 | Distributor candidate present |
| cand_id_i | input | 10 | Candidate source number |
| cand_prio_i | input | 8 | Candidate priority value (lower is more urgent) |
| cand_src_i | input | 3 | Requesting processor for software-generated sources |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_vld_o | output | 1 | One-cycle acknowledge notice to the distributor |
| ack_id_o | output | 10 | Source number being acknowledged |
| eoi_vld_o | output | 1 | One-cycle completion notice to the distributor |
| eoi_id_o | output | 10 | Source number being completed |

## Verification
Every priority value from 0 to 255 is swept against the thresholds 0, 1, 0x80, 0xF0 and 0xFF, which separates a strict comparison from an inclusive one and exposes a threshold that is ignored. Source numbers 0 to 40 and 1019 each go through a full acknowledge and completion round trip, with the requesting processor number varied. This tells the software-generated range, which carries bits 12:10, from the rest. The same round trip also exercises the stray completion in between, the acknowledge read while busy, the idle read, the disabled interface and the reserved numbers 1020 to 1023. Together these tell apart an acknowledge with side effects from a read without them.

// File: rtl/cpu_irq_iface_pkg.sv
package cpu_irq_iface_pkg;
  // register word slots; software depends on this placement
  localparam logic [1:0] SLOT_CTRL = 2'd0;
  localparam logic [1:0] SLOT_PMSK = 2'd1;
  localparam logic [1:0] SLOT_ACK  = 2'd2;
  localparam logic [1:0] SLOT_EOI  = 2'd3;
endpackage

// File: rtl/cpu_irq_iface_cfg.sv
module cpu_irq_iface_cfg #(
  parameter int DATA_W = 32,
  parameter int PRIO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_pmsk_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic [PRIO_W-1:0] pmsk_o
);
  logic              en_q, en_d;
  logic [PRIO_W-1:0] pmsk_q, pmsk_d;

  always_comb begin
    en_d   = en_q;
    pmsk_d = pmsk_q;
    if (wr_ctrl_i) en_d   = wdata_i[0];
    if (wr_pmsk_i) pmsk_d = wdata_i[PRIO_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pmsk_q <= '0;
    end else begin
      if (wr_ctrl_i) en_q   <= en_d;
      if (wr_pmsk_i) pmsk_q <= pmsk_d;
    end
  end

  assign en_o   = en_q;
  assign pmsk_o = pmsk_q;
endmodule

// File: rtl/cpu_irq_iface_qual.sv
module cpu_irq_iface_qual #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int CPU_W  = 3,
  parameter int SGI_N  = 16
) (
  input  logic              en_i,
  input  logic [PRIO_W-1:0] pmsk_i,
  input  logic              busy_i,
  input  logic              cand_vld_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [CPU_W-1:0]  cand_src_i,
  output logic              qualify_o,
  output logic [DATA_W-1:0] ack_word_o
);
  localparam logic [ID_W-1:0] NONE_ID = {ID_W{1'b1}};
  localparam logic [ID_W-1:0] RSV_LO  = NONE_ID - ID_W'(3);
  localparam logic [ID_W-1:0] SGI_LIM = ID_W'(SGI_N);
  localparam int              PAD_W   = DATA_W - ID_W - CPU_W;

  logic             id_legal;
  logic             below_thr;
  logic [CPU_W-1:0] src_field;

  assign id_legal  = cand_id_i < RSV_LO;
  assign below_thr = cand_prio_i < pmsk_i;
  assign qualify_o = en_i & cand_vld_i & id_legal & below_thr & ~busy_i;
  assign src_field = (cand_id_i < SGI_LIM) ? cand_src_i : '0;

  always_comb begin
    if (qualify_o) ack_word_o = {{PAD_W{1'b0}}, src_field, cand_id_i};
    else           ack_word_o = {{(DATA_W-ID_W){1'b0}}, NONE_ID};
  end
endmodule

// File: rtl/cpu_irq_iface_slot.sv
module cpu_irq_iface_slot #(
  parameter int ID_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic [ID_W-1:0] take_id_i,
  input  logic            done_wr_i,
  input  logic [ID_W-1:0] done_id_i,
  output logic            busy_o,
  output logic            ack_vld_o,
  output logic [ID_W-1:0] ack_id_o,
  output logic            eoi_vld_o,
  output logic [ID_W-1:0] eoi_id_o
);
  logic            busy_q, busy_d;
  logic [ID_W-1:0] svc_q, svc_d;
  logic            ackp_q, ackp_d;
  logic [ID_W-1:0] ackid_q;
  logic            eoip_q, eoip_d;
  logic [ID_W-1:0] eoiid_q;
  logic            done_hit;

  assign done_hit = done_wr_i & busy_q & (done_id_i == svc_q);

  always_comb begin
    busy_d = busy_q;
    svc_d  = svc_q;
    ackp_d = 1'b0;
    eoip_d = 1'b0;
    if (take_i) begin
      busy_d = 1'b1;
      svc_d  = take_id_i;
      ackp_d = 1'b1;
    end else if (done_hit) begin
      busy_d = 1'b0;
      eoip_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      svc_q   <= '0;
      ackp_q  <= 1'b0;
      ackid_q <= '0;
      eoip_q  <= 1'b0;
      eoiid_q <= '0;
    end else begin
      busy_q <= busy_d;
      ackp_q <= ackp_d;
      eoip_q <= eoip_d;
      if (take_i) begin
        svc_q   <= svc_d;
        ackid_q <= take_id_i;
      end
      if (done_hit) eoiid_q <= done_id_i;
    end
  end

  assign busy_o    = busy_q;
  assign ack_vld_o = ackp_q;
  assign ack_id_o  = ackid_q;
  assign eoi_vld_o = eoip_q;
  assign eoi_id_o  = eoiid_q;
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int CPU_W  = 3,
  parameter int SGI_N  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              cand_vld_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [CPU_W-1:0]  cand_src_i,
  output logic              irq_o,
  output logic              ack_vld_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              eoi_vld_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  import cpu_irq_iface_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic              en_q;
  logic [PRIO_W-1:0] pmsk_q;
  logic              busy;
  logic              qualify;
  logic [DATA_W-1:0] ack_word;
  logic              wr_ctrl, wr_pmsk, wr_eoi, rd_ack;

  assign wr_ctrl = reg_wr_i & (reg_addr_i == SLOT_CTRL);
  assign wr_pmsk = reg_wr_i & (reg_addr_i == SLOT_PMSK);
  assign wr_eoi  = reg_wr_i & (reg_addr_i == SLOT_EOI);
  assign rd_ack  = reg_rd_i & (reg_addr_i == SLOT_ACK);

  cpu_irq_iface_cfg #(.DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_ctrl_i (wr_ctrl),
    .wr_pmsk_i (wr_pmsk),
    .wdata_i   (reg_wdata_i),
    .en_o      (en_q),
    .pmsk_o    (pmsk_q)
  );

  cpu_irq_iface_qual #(
    .DATA_W(DATA_W), .ID_W(ID_W), .PRIO_W(PRIO_W), .CPU_W(CPU_W), .SGI_N(SGI_N)
  ) u_qual (
    .en_i        (en_q),
    .pmsk_i      (pmsk_q),
    .busy_i      (busy),
    .cand_vld_i  (cand_vld_i),
    .cand_id_i   (cand_id_i),
    .cand_prio_i (cand_prio_i),
    .cand_src_i  (cand_src_i),
    .qualify_o   (qualify),
    .ack_word_o  (ack_word)
  );

  cpu_irq_iface_slot #(.ID_W(ID_W)) u_slot (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .take_i    (rd_ack & qualify),
    .take_id_i (cand_id_i),
    .done_wr_i (wr_eoi),
    .done_id_i (reg_wdata_i[ID_W-1:0]),
    .busy_o    (busy),
    .ack_vld_o (ack_vld_o),
    .ack_id_o  (ack_id_o),
    .eoi_vld_o (eoi_vld_o),
    .eoi_id_o  (eoi_id_o)
  );

  // read data path
  logic [DATA_W-1:0] rdata_d, rdata_q;
  always_comb begin
    unique case (reg_addr_i)
      SLOT_CTRL: rdata_d = {{(DATA_W-1){1'b0}}, en_q};
      SLOT_PMSK: rdata_d = {{(DATA_W-PRIO_W){1'b0}}, pmsk_q};
      SLOT_ACK:  rdata_d = ack_word;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (reg_rd_i) rdata_q <= rdata_d;
  end

  assign reg_rdata_o = rdata_q;
  assign irq_o       = qualify;
endmodule

// File: rtl/cpu_irq_iface_chk.sv
module cpu_irq_iface_chk #(
  parameter int ADDR_W = 2,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              en,
  input logic [PRIO_W-1:0] pmsk,
  input logic              busy,
  input logic              reg_rd_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [ID_W-1:0]   cand_id_i,
  input logic [PRIO_W-1:0] cand_prio_i,
  input logic              irq_o,
  input logic              ack_vld_o,
  input logic [ID_W-1:0]   ack_id_o,
  input logic              eoi_vld_o
);
  localparam logic [ID_W-1:0] RSV_LO = {ID_W{1'b1}} - ID_W'(3);

  // R2
  irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> en);
  // R3
  irq_below_thr_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (cand_prio_i < pmsk));
  // R5
  ack_drops_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ack_vld_o |-> (!irq_o && busy));
  // R6
  idle_read_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (reg_rd_i && reg_addr_i == 2'd2 && !irq_o) |=> !ack_vld_o);
  // R7
  no_rsv_id_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o |-> (cand_id_i < RSV_LO));
  // R7
  ack_id_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ack_vld_o |-> (ack_id_o < RSV_LO));
  // R8
  eoi_from_write_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    eoi_vld_o |-> $past(reg_wr_i && reg_addr_i == 2'd3));
  // R9
  eoi_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    eoi_vld_o |-> ($past(busy) && !busy));
endmodule

bind cpu_irq_iface cpu_irq_iface_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .PRIO_W(PRIO_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .en          (en_q),
  .pmsk        (pmsk_q),
  .busy        (busy),
  .reg_rd_i    (reg_rd_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .cand_id_i   (cand_id_i),
  .cand_prio_i (cand_prio_i),
  .irq_o       (irq_o),
  .ack_vld_o   (ack_vld_o),
  .ack_id_o    (ack_id_o),
  .eoi_vld_o   (eoi_vld_o)
);

// File: tb/cpu_irq_iface_tb_top.sv
`timescale 1ns/1ps
module cpu_irq_iface_tb_top;
  logic        clk;
  logic        rst_n;
  logic        rd, wr;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        cvld;
  logic [9:0]  cid;
  logic [7:0]  cprio;
  logic [2:0]  csrc;
  logic        irq, ackv, eoiv;
  logic [9:0]  ackid, eoiid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  cpu_irq_iface dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .cand_vld_i(cvld), .cand_id_i(cid), .cand_prio_i(cprio), .cand_src_i(csrc),
    .irq_o(irq), .ack_vld_o(ackv), .ack_id_o(ackid),
    .eoi_vld_o(eoiv), .eoi_id_o(eoiid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
    d = rdata;
  endtask

  function automatic logic [31:0] ack_exp(input int id, input int src);
    if (id < 16) return 32'((src << 10) | id);
    return 32'(id);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int masks [5] = '{0, 1, 8'h80, 8'hF0, 8'hFF};
    rst_n = 1'b0; rd = 0; wr = 0; addr = 0; wdata = 0;
    cvld = 0; cid = 0; cprio = 0; csrc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 ack pulse", 32'(ackv), 0);
    chk("R1 eoi pulse", 32'(eoiv), 0);
    reg_rd(2'd0, v); chk("R1 ctrl", v, 0);
    reg_rd(2'd1, v); chk("R1 pmask", v, 0);

    // R2 disabled interface keeps the line low
    cvld = 1; cid = 10'd40; cprio = 8'h10;
    reg_wr(2'd1, 32'hFFFF_FFF0);
    #1 chk("R2 disabled irq", 32'(irq), 0);
    reg_rd(2'd1, v); chk("R2 pmask readback", v, 32'hF0);
    reg_wr(2'd0, 32'hFFFF_FFFF);
    reg_rd(2'd0, v); chk("R2 ctrl readback", v, 1);
    #1 chk("R2 enabled irq", 32'(irq), 1);

    // R3 priority sweep against thresholds
    foreach (masks[m]) begin
      reg_wr(2'd1, 32'(masks[m]));
      for (int p = 0; p < 256; p++) begin
        @(negedge clk); cprio = 8'(p);
        #1 chk("R3 prio vs mask", 32'(irq), 32'(p < masks[m]));
      end
    end
    @(negedge clk); cvld = 0; cprio = 0;
    #1 chk("R3 no candidate", 32'(irq), 0);

    // R4 R5 R6 R8 R9 round trips
    reg_wr(2'd1, 32'hFF);
    for (int i = 0; i <= 41; i++) begin
      automatic int id = (i == 41) ? 1019 : i;
      automatic int src = i % 8;
      @(negedge clk); cvld = 1; cid = 10'(id); csrc = 3'(src);
      #1 chk("R3 qualifying", 32'(irq), 1);
      reg_rd(2'd2, v);
      chk("R4 ack word", v, ack_exp(id, src));
      chk("R5 ack pulse", 32'(ackv), 1);
      chk("R5 ack id", 32'(ackid), 32'(id));
      chk("R5 irq after ack", 32'(irq), 0);
      reg_rd(2'd2, v);
      chk("R6 busy read", v, 32'd1023);
      chk("R6 busy no pulse", 32'(ackv), 0);
      reg_wr(2'd3, 32'(id ^ 1));
      chk("R9 stray eoi", 32'(eoiv), 0);
      chk("R9 still busy", 32'(irq), 0);
      reg_wr(2'd3, 32'(id));
      chk("R8 eoi pulse", 32'(eoiv), 1);
      chk("R8 eoi id", 32'(eoiid), 32'(id));
      #1 chk("R8 irq back", 32'(irq), 1);
    end

    // R6 idle read, R9 eoi with nothing in service
    @(negedge clk); cvld = 0;
    reg_rd(2'd2, v);
    chk("R6 idle read", v, 32'd1023);
    chk("R6 idle no pulse", 32'(ackv), 0);
    reg_wr(2'd3, 32'd1019);
    chk("R9 idle eoi", 32'(eoiv), 0);
    @(negedge clk); cvld = 1; cid = 10'd5;
    #1 chk("R6 state unchanged", 32'(irq), 1);

    // R7 reserved numbers
    for (int r = 1020; r < 1024; r++) begin
      @(negedge clk); cid = 10'(r);
      #1 chk("R7 reserved irq", 32'(irq), 0);
      reg_rd(2'd2, v);
      chk("R7 reserved read", v, 32'd1023);
      chk("R7 reserved pulse", 32'(ackv), 0);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule